// File: doc/BRIEF.md
# Module Presence-Detect Configuration Memory

This block models a 256-byte non-volatile configuration memory that a host reads over a two-wire serial bus, of the kind fitted to memory modules so the host can learn their organisation and timing. The block runs on a fast system clock. It oversamples the serial clock and data lines, detects start and stop conditions, and acts as a bus target. It answers only to a 7-bit device address: the fixed upper four bits are 1010b and the lower three bits come from strap pins.

The host sets a byte pointer with a word-address byte and then either writes bytes or issues a repeated start and reads. Reads can continue for any length, and the pointer advances after each byte and wraps. The lower half of the array holds factory data. Writes there are acknowledged and then thrown away. A side port lets the surrounding system preload any byte, whatever the lock, which is how the initial image gets in. A status output reports whether byte 63 matches the 8-bit sum of bytes 0 to 62.

The data line is open-drain. The block never drives it high; it only asserts an enable that pulls it low.

Top module: `spdEeprom`

## Requirements
- R1: After reset the block releases the data line (sdaOe low) and keeps it released until a start condition is followed by an address byte that matches.
- R2: The block acknowledges on the ninth clock only when the seven address bits sent MSB first equal {1010b, strap}; a non-matching address gets no acknowledge, and the block stays released for the rest of that transaction.
- R3: In a write, the second byte loads the byte pointer and each following data byte is acknowledged. A byte whose pointer is 128 or above is stored there, and the pointer then advances by one.
- R4: A data byte written while the pointer is below 128 is acknowledged but leaves the array unchanged, and the pointer still advances.
- R5: After a matching address with the read bit (LSB = 1), the block drives the byte at the pointer MSB first. sdaOe changes only while SCL is low and stays steady through each SCL-high phase.
- R6: When the host acknowledges a read byte, the next byte follows; the pointer advances once per byte sent and wraps from 255 to 0, in reads and writes alike.
- R7: When the host does not acknowledge a read byte, the block releases the line and stays released until the next start.
- R8: A stop, or a repeated start, that arrives inside a byte discards that partial byte: nothing is written and the pointer keeps its value.
- R9: A read that has no word-address byte starts at the pointer left by the previous transfer.
- R10: csumOk is high exactly when byte 63 equals the low 8 bits of the sum of bytes 0 to 62. It follows the array from the clock edge that writes it, and the load port writes any byte, locked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset of the bus logic |
| scl | input | 1 | Serial bus clock |
| sdaIn | input | 1 | Sensed level of the serial data line |
| sdaOe | output | 1 | When high, pull the data line low |
| strap | input | 3 | Low three bits of the device address |
| loadEn | input | 1 | Preload strobe for one array byte |
| loadAddr | input | 8 | Preload byte index |
| loadData | input | 8 | Preload byte value |
| csumOk | output | 1 | Stored checksum matches the lower bytes |

## Verification
Each bus result reaches sdaOe two or three system clocks after the SCL fall that precedes it. This delay comes from one input register, one edge-detect register and the state register. The bench therefore holds SCL low for eight clocks before each rise and compares sdaOe with its model only while SCL is high, when the value must be steady. csumOk depends on the array without any register in between, so it is due right after the edge that takes a preload. The bench updates its own image just after that edge and compares the flag on every falling clock edge. Ignored writes are shown through the bus by reading the same locations back.

// File: rtl/spdEepromPkg.sv
package spdEepromPkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WORD,
    S_WACK,
    S_WDATA,
    S_DACK,
    S_RDATA,
    S_RACK
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic rxBit;
    logic loadPtr;
    logic writeByte;
    logic loadTx;
    logic shiftOut;
  } spdStrobes_t;

endpackage

// File: rtl/spdBusCtrl.sv
module spdBusCtrl
  import spdEepromPkg::*;
#(
  parameter int STRAP_W = 3,
  parameter logic [6-STRAP_W:0] DEV_TYPE = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scl,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  input  logic [7:0]         rxByte,
  input  logic               txMsb,
  output spdStrobes_t        stb,
  output logic               sdaOe
);

  busState_t state;
  logic [3:0] bitCnt;
  logic sclQ, sclPrev, sdaQ, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;
  logic rxState, byteFull, addrHit;

  assign sclRise   = sclQ & ~sclPrev;
  assign sclFall   = ~sclQ & sclPrev;
  assign startSeen = sclQ & sclPrev & sdaPrev & ~sdaQ;
  assign stopSeen  = sclQ & sclPrev & ~sdaPrev & sdaQ;
  assign rxState   = (state == S_ADDR) || (state == S_WORD) || (state == S_WDATA);
  assign byteFull  = (bitCnt == 4'd8);
  assign addrHit   = (rxByte[7:1] == {DEV_TYPE, strap});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sclPrev <= 1'b1;
      sdaQ    <= 1'b1;
      sdaPrev <= 1'b1;
      state   <= S_IDLE;
      bitCnt  <= '0;
    end else begin
      sclQ    <= scl;
      sclPrev <= sclQ;
      sdaQ    <= sdaIn;
      sdaPrev <= sdaQ;
      if (startSeen) begin
        state  <= S_ADDR;
        bitCnt <= '0;
      end else if (stopSeen) begin
        state  <= S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_WORD, S_WDATA: begin
            if (sclRise && !byteFull) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && byteFull) begin
              bitCnt <= '0;
              if (state == S_ADDR)      state <= addrHit ? S_AACK : S_IDLE;
              else if (state == S_WORD) state <= S_WACK;
              else                      state <= S_DACK;
            end
          end
          S_AACK:         if (sclFall) state <= rxByte[0] ? S_RDATA : S_WORD;
          S_WACK, S_DACK: if (sclFall) state <= S_WDATA;
          S_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && byteFull) begin
              bitCnt <= '0;
              state  <= S_RACK;
            end
          end
          S_RACK: begin
            if (sclRise && sdaQ) state <= S_IDLE;
            else if (sclFall)    state <= S_RDATA;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb.rxBit     = sdaQ;
    stb.shiftIn   = rxState && sclRise && !byteFull;
    stb.loadPtr   = (state == S_WORD) && sclFall && byteFull;
    stb.writeByte = (state == S_WDATA) && sclFall && byteFull;
    stb.loadTx    = ((state == S_ADDR) && sclFall && byteFull && addrHit && rxByte[0])
                 || ((state == S_RACK) && sclRise && !sdaQ);
    stb.shiftOut  = (state == S_RDATA) && sclFall && !byteFull;
  end

  assign sdaOe = (state == S_AACK) || (state == S_WACK) || (state == S_DACK)
              || ((state == S_RDATA) && !txMsb);

endmodule

// File: rtl/spdDataPath.sv
module spdDataPath
  import spdEepromPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LOCK_BYTES = 128,
  parameter int CSUM_POS   = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  spdStrobes_t       stb,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] ptrVal,
  output logic              csumOk
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LOCK_LIM = ADDR_W'(LOCK_BYTES);

  logic [7:0] mem [DEPTH];
  logic [7:0] txReg;
  logic [7:0] sumAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte <= '0;
      txReg  <= 8'hFF;
      ptrVal <= '0;
    end else begin
      if (stb.shiftIn) rxByte <= {rxByte[6:0], stb.rxBit};
      if (stb.loadTx)        txReg <= mem[ptrVal];
      else if (stb.shiftOut) txReg <= {txReg[6:0], 1'b1};
      if (stb.loadPtr)                      ptrVal <= rxByte[ADDR_W-1:0];
      else if (stb.writeByte || stb.loadTx) ptrVal <= ptrVal + ADDR_W'(1);
    end
  end

  // Array contents are not reset: they model non-volatile storage.
  always_ff @(posedge clk) begin
    if (loadEn)
      mem[loadAddr] <= loadData;
    else if (rstN && stb.writeByte && (ptrVal >= LOCK_LIM))
      mem[ptrVal] <= rxByte;
  end

  always_comb begin
    sumAcc = '0;
    for (int i = 0; i < CSUM_POS; i++) sumAcc = sumAcc + mem[i];
  end

  assign csumOk = (sumAcc == mem[CSUM_POS]);
  assign txMsb  = txReg[7];

endmodule

// File: rtl/spdEeprom.sv
module spdEeprom
  import spdEepromPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LOCK_BYTES = 128,
  parameter int CSUM_POS   = 63,
  parameter int STRAP_W    = 3,
  parameter logic [6-STRAP_W:0] DEV_TYPE = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scl,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [STRAP_W-1:0] strap,
  input  logic               loadEn,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [7:0]         loadData,
  output logic               csumOk
);

  spdStrobes_t stb;
  logic [7:0] rxByte;
  logic txMsb;
  logic [ADDR_W-1:0] ptrVal;

  spdBusCtrl #(.STRAP_W(STRAP_W), .DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaIn), .strap(strap),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaOe(sdaOe)
  );

  spdDataPath #(.ADDR_W(ADDR_W), .LOCK_BYTES(LOCK_BYTES), .CSUM_POS(CSUM_POS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .rxByte(rxByte), .txMsb(txMsb), .ptrVal(ptrVal),
    .csumOk(csumOk)
  );

endmodule

// File: rtl/spdEepromChecker.sv
module spdEepromChecker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              loadEn,
  input logic              sdaOe,
  input logic              csumOk,
  input logic              shiftIn,
  input logic              loadPtr,
  input logic              writeByte,
  input logic              loadTx,
  input logic              shiftOut,
  input logic [ADDR_W-1:0] ptrVal
);

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl) && $past(scl, 2)) |-> $stable(sdaOe)); // R5

  AST_PTR_STEP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    writeByte |=> (ptrVal == $past(ptrVal) + ADDR_W'(1))); // R4

  AST_PTR_STEP_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    loadTx |=> (ptrVal == $past(ptrVal) + ADDR_W'(1))); // R6

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shiftIn, loadPtr, writeByte, loadTx, shiftOut})); // R3

  AST_CSUM_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(csumOk)); // R10

endmodule

bind spdEeprom spdEepromChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .scl(scl), .loadEn(loadEn), .sdaOe(sdaOe),
  .csumOk(csumOk), .shiftIn(stb.shiftIn), .loadPtr(stb.loadPtr),
  .writeByte(stb.writeByte), .loadTx(stb.loadTx), .shiftOut(stb.shiftOut),
  .ptrVal(ptrVal)
);

// File: tb/test_spdEeprom.sv
module test_spdEeprom;

  logic clk = 1'b0;
  logic rstN, scl, hostSda, loadEn;
  logic [2:0] strap;
  logic [7:0] loadAddr, loadData;
  logic sdaOe, csumOk, sdaBus;

  logic [7:0] mdl [256];
  logic [7:0] mPtr;
  logic expDrive, csumOn, done;
  string curReq;
  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;
  assign sdaBus = hostSda & ~sdaOe;

  spdEeprom i_spdEeprom (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strap(strap), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .csumOk(csumOk)
  );

  function automatic logic modelCsum();
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 63; i++) s = s + mdl[i];
    return s == mdl[63];
  endfunction

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rstN === 1'b1 && scl === 1'b1 && !done) begin
      nChecks++;
      if (sdaOe !== expDrive) begin
        nFails++;
        $display("FAIL %s sdaOe actual %0b expected %0b at %0t", curReq, sdaOe, expDrive, $time);
      end
    end
    if (csumOn && !done) begin
      nChecks++;
      if (csumOk !== modelCsum()) begin
        nFails++;
        $display("FAIL R10 csumOk actual %0b expected %0b at %0t", csumOk, modelCsum(), $time);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic busBit(input logic hb, input logic expOe);
    scl = 1'b0; waitClk(2);
    hostSda = hb; expDrive = expOe; waitClk(6);
    scl = 1'b1; waitClk(8);
  endtask

  task automatic startC();
    scl = 1'b0; waitClk(2);
    hostSda = 1'b1; expDrive = 1'b0; waitClk(6);
    scl = 1'b1; waitClk(4);
    hostSda = 1'b0; waitClk(4);
  endtask

  task automatic stopC();
    scl = 1'b0; waitClk(2);
    hostSda = 1'b0; expDrive = 1'b0; waitClk(6);
    scl = 1'b1; waitClk(4);
    hostSda = 1'b1; waitClk(4);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck);
    for (int i = 7; i >= 0; i--) busBit(b[i], 1'b0);
    busBit(1'b1, expAck);
  endtask

  task automatic readByte(input logic [7:0] expB, input logic hostAck);
    for (int i = 7; i >= 0; i--) busBit(1'b1, ~expB[i]);
    busBit(~hostAck, 1'b0);
  endtask

  task automatic wrData(input logic [7:0] d);
    sendByte(d, 1'b1);
    if (mPtr >= 8'd128) mdl[mPtr] = d;
    mPtr = mPtr + 8'd1;
  endtask

  task automatic rdData(input logic hostAck);
    readByte(mdl[mPtr], hostAck);
    mPtr = mPtr + 8'd1;
  endtask

  task automatic loadByte(input logic [7:0] a, input logic [7:0] d);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    waitClk(1);
    mdl[a] = d;
    loadEn = 1'b0;
  endtask

  function automatic logic [7:0] devW();
    return {4'b1010, strap, 1'b0};
  endfunction

  function automatic logic [7:0] devR();
    return {4'b1010, strap, 1'b1};
  endfunction

  initial begin
    logic [7:0] img [256];
    logic [7:0] s;
    rstN = 1'b0; scl = 1'b1; hostSda = 1'b1; loadEn = 1'b0;
    loadAddr = '0; loadData = '0; strap = 3'b101;
    expDrive = 1'b0; csumOn = 1'b0; done = 1'b0; curReq = "R1"; mPtr = '0;
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    checkBit("R1", sdaOe, 1'b0);

    // image: size bytes, patterned body, checksum at 63, writable upper half
    s = 8'h00;
    for (int i = 0; i < 256; i++) begin
      if (i == 0)       img[i] = 8'h80;
      else if (i == 1)  img[i] = 8'h08;
      else if (i < 63)  img[i] = 8'(i * 7 + 3);
      else if (i == 63) img[i] = 8'h00;
      else              img[i] = 8'(i) ^ 8'h5A;
      if (i < 63) s = s + img[i];
    end
    img[63] = s;
    for (int i = 0; i < 256; i++) loadByte(8'(i), img[i]);
    csumOn = 1'b1;
    waitClk(2);
    checkBit("R10", csumOk, 1'b1);

    // R2: wrong address gets no acknowledge, later bytes ignored
    curReq = "R2";
    startC(); sendByte({4'b1010, 3'b110, 1'b0}, 1'b0); sendByte(8'h3C, 1'b0); stopC();
    startC(); sendByte(8'h20 | {5'b0, strap}, 1'b0); stopC();
    strap = 3'b010;
    waitClk(4);

    // R3: write upper bytes, wrap into locked byte 0 (R4, R6)
    curReq = "R3";
    startC(); sendByte(devW(), 1'b1); sendByte(8'hFE, 1'b1); mPtr = 8'hFE;
    wrData(8'h11); wrData(8'h22);
    curReq = "R6"; wrData(8'h33);
    stopC();

    // R5: random read across the wrap, then R7 host NACK
    curReq = "R5";
    startC(); sendByte(devW(), 1'b1); sendByte(8'hFE, 1'b1); mPtr = 8'hFE;
    startC(); sendByte(devR(), 1'b1);
    rdData(1'b1);
    curReq = "R6"; rdData(1'b1); rdData(1'b0);
    curReq = "R7"; sendByte(8'hFF, 1'b0); sendByte(8'hFF, 1'b0);
    stopC();

    // R4: locked writes acknowledged, contents unchanged on readback
    curReq = "R4";
    startC(); sendByte(devW(), 1'b1); sendByte(8'h05, 1'b1); mPtr = 8'h05;
    wrData(8'hAA); wrData(8'hBB); stopC();
    checkBit("R4", mPtr == 8'h07, 1'b1);
    startC(); sendByte(devW(), 1'b1); sendByte(8'h05, 1'b1); mPtr = 8'h05;
    startC(); sendByte(devR(), 1'b1); rdData(1'b1); rdData(1'b1); rdData(1'b0); stopC();

    // R3 / R6: multi-byte write in upper half and sequential readback
    curReq = "R3";
    startC(); sendByte(devW(), 1'b1); sendByte(8'h80, 1'b1); mPtr = 8'h80;
    wrData(8'hC1); wrData(8'hC2); wrData(8'hC3); wrData(8'hC4); stopC();
    curReq = "R6";
    startC(); sendByte(devW(), 1'b1); sendByte(8'h80, 1'b1); mPtr = 8'h80;
    startC(); sendByte(devR(), 1'b1);
    rdData(1'b1); rdData(1'b1); rdData(1'b1); rdData(1'b0); stopC();

    // R8: stop inside a data byte; R9: current-address read
    curReq = "R8";
    startC(); sendByte(devW(), 1'b1); sendByte(8'h90, 1'b1); mPtr = 8'h90;
    for (int i = 0; i < 4; i++) busBit(1'b0, 1'b0);
    stopC();
    curReq = "R9";
    startC(); sendByte(devR(), 1'b1); rdData(1'b1); rdData(1'b0); stopC();

    // R8: repeated start inside a data byte
    curReq = "R8";
    startC(); sendByte(devW(), 1'b1); sendByte(8'hA0, 1'b1); mPtr = 8'hA0;
    for (int i = 0; i < 3; i++) busBit(1'b0, 1'b0);
    startC(); sendByte(devR(), 1'b1); rdData(1'b0); stopC();

    // R10: preload bypasses lock and moves the checksum flag
    curReq = "R10";
    loadByte(8'd10, mdl[10] ^ 8'h01);
    waitClk(3);
    checkBit("R10", csumOk, 1'b0);
    loadByte(8'd10, mdl[10] ^ 8'h01);
    waitClk(3);
    checkBit("R10", csumOk, 1'b1);
    loadByte(8'd63, mdl[63] + 8'd1);
    waitClk(2);
    checkBit("R10", csumOk, 1'b0);

    waitClk(10);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule